// File: doc/BRIEF.md
# Multichannel DMA address sequencer

This block keeps the transfer descriptors for a bank of DMA channels and, each time a channel is serviced, reports the source and destination addresses of that transfer. Each channel holds a base address and a signed step for each side, a block length, a service period and an addressing style. In linear style the channel walks through one block and then halts. In circular style it returns to its base addresses after every block and keeps running. A per-channel down-counter paces each channel's requests. A round-robin scheduler services one requesting channel per cycle.

The end of each block is an event. A small set of interrupt lines can watch these events. Each line has its own channel selector and a sticky pending flag, which software clears by writing a one. Software programs the descriptors through a narrow write port that takes a channel index, a field code and a data word. The memory data path belongs to neighbouring logic, which consumes the registered address pair.

Top module: `dma_addr_seq`

## Requirements
- R1: During and after synchronous reset, `out_vld` is 0, `out_ch`, `out_src` and `out_dst` are 0, and `irq_out` is all zero.
- R2: The channel is started by a write of field code 6 (control) with bit 0 = 1. Bit 1 selects circular style when 1 and linear style when 0. The start loads both pointers from the base fields (codes 0 source, 1 destination). With service period P (field code 5), the first transfer appears on the output P+1 cycles after the start write.
- R3: Each transfer after the first in a block adds that side's step to the address of the previous transfer. The step is field code 2 for source and 3 for destination. Steps are two's-complement and the addition wraps at ADDR_W bits.
- R4: In linear style the channel delivers exactly L transfers, where L is field code 4. It then stops and produces no further transfers until it is started again.
- R5: In circular style, the transfer after the L-th of a block returns to the base addresses, and the channel keeps running indefinitely.
- R6: A channel that is alone in requesting is serviced once every P+1 cycles.
- R7: One channel is granted per cycle, and only a channel that is requesting. No cycle is left idle while any channel requests. Channels that request continuously are served in cyclic index order. The grant appears one cycle later as `out_vld`, `out_ch` and the address pair.
- R8: The transfer that completes a block, in either style, sets the pending flag of every interrupt line whose selector names that channel. The flag is set at the same clock edge that presents that transfer on the output.
- R9: A pending flag stays set until a 1 is written to its bit of `irq_clr`. A new block end in the same cycle as the clear takes precedence, and the flag stays set.
- R10: After reset, interrupt line k watches channel k. A selector write (`irq_wr`) reroutes line `irq_idx` to channel `irq_ch`. A line that watches an idle channel stays clear.
- R11: A control write with bit 0 = 0 stops the channel, and it issues no further transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Descriptor field write strobe |
| cfg_ch | input | CH_W | Channel addressed by the write |
| cfg_fld | input | 3 | Field code: 0 src base, 1 dst base, 2 src step, 3 dst step, 4 length, 5 period, 6 control |
| cfg_wdata | input | ADDR_W | Write data |
| irq_wr | input | 1 | Interrupt selector write strobe |
| irq_idx | input | IRQ_W | Interrupt line whose selector is written |
| irq_ch | input | CH_W | Channel that the line will watch |
| irq_clr | input | NIRQ | Write-one-to-clear of the pending flags |
| out_vld | output | 1 | A transfer was scheduled |
| out_ch | output | CH_W | Channel of that transfer |
| out_src | output | ADDR_W | Source address of that transfer |
| out_dst | output | ADDR_W | Destination address of that transfer |
| irq_out | output | NIRQ | Pending interrupt flags |

## Verification
The bench builds the block with its defaults: twelve channels, six interrupt lines, 16-bit addresses, 10-bit lengths and 8-bit periods. A negative source step can therefore cross zero and wrap to 0xFFFE inside one circular block. Channels 2, 5 and 9 run together, so the round-robin pointer has to wrap past index 11 back to 0 while they compete. Periods of 0, 2, 5 and 6 cycles test both the first-service delay and the steady spacing, and a one-transfer block puts a block end in the same cycle as a pending clear.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  // Descriptor field codes on the configuration port
  typedef enum logic [2:0] {
    FLD_SRC_BASE = 3'd0,
    FLD_DST_BASE = 3'd1,
    FLD_SRC_STEP = 3'd2,
    FLD_DST_STEP = 3'd3,
    FLD_COUNT    = 3'd4,
    FLD_PERIOD   = 3'd5,
    FLD_CTRL     = 3'd6
  } fld_e;

  // Control word bit positions
  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_WRAP_BIT = 1;

endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 10,
  parameter int IVL_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_fld,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              grant,
  output logic              req,
  output logic [ADDR_W-1:0] src_ptr,
  output logic [ADDR_W-1:0] dst_ptr,
  output logic              blk_end
);

  logic [ADDR_W-1:0] src_base, dst_base, src_step, dst_step;
  logic [LEN_W-1:0]  blk_len, xfer_cnt;
  logic [IVL_W-1:0]  period, timer;
  logic              active, wrap_mode, finished;
  logic              last_xfer;

  assign last_xfer = (xfer_cnt + LEN_W'(1)) == blk_len;
  assign req       = active & ~finished & (timer == '0);
  assign blk_end   = grant & last_xfer;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_base  <= '0;
      dst_base  <= '0;
      src_step  <= '0;
      dst_step  <= '0;
      blk_len   <= '0;
      period    <= '0;
      active    <= 1'b0;
      wrap_mode <= 1'b0;
      finished  <= 1'b0;
      xfer_cnt  <= '0;
      timer     <= '0;
      src_ptr   <= '0;
      dst_ptr   <= '0;
    end else if (wr_en) begin
      case (wr_fld)
        FLD_SRC_BASE: src_base <= wr_data;
        FLD_DST_BASE: dst_base <= wr_data;
        FLD_SRC_STEP: src_step <= wr_data;
        FLD_DST_STEP: dst_step <= wr_data;
        FLD_COUNT:    blk_len  <= wr_data[LEN_W-1:0];
        FLD_PERIOD:   period   <= wr_data[IVL_W-1:0];
        FLD_CTRL: begin
          active    <= wr_data[CTRL_RUN_BIT];
          wrap_mode <= wr_data[CTRL_WRAP_BIT];
          src_ptr   <= src_base;
          dst_ptr   <= dst_base;
          xfer_cnt  <= '0;
          timer     <= period;
          finished  <= 1'b0;
        end
        default: ;
      endcase
    end else if (grant) begin
      timer <= period;
      if (last_xfer) begin
        xfer_cnt <= '0;
        src_ptr  <= src_base;
        dst_ptr  <= dst_base;
        if (!wrap_mode) finished <= 1'b1;
      end else begin
        xfer_cnt <= xfer_cnt + LEN_W'(1);
        src_ptr  <= src_ptr + src_step;
        dst_ptr  <= dst_ptr + dst_step;
      end
    end else if (active && !finished && timer != '0) begin
      timer <= timer - IVL_W'(1);
    end
  end

endmodule

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
  parameter int N = 12,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic         gnt_vld,
  output logic [W-1:0] gnt_idx
);

  logic [W-1:0] ptr;

  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    for (int off = 0; off < N; off++) begin
      int cand;
      cand = int'(ptr) + off;
      if (cand >= N) cand = cand - N;
      if (!gnt_vld && req[W'(cand)]) begin
        gnt_vld = 1'b1;
        gnt_idx = W'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (gnt_vld) begin
      ptr <= (gnt_idx == W'(N - 1)) ? '0 : gnt_idx + W'(1);
    end
  end

endmodule

// File: rtl/dma_irq_route.sv
module dma_irq_route #(
  parameter int NCH  = 12,
  parameter int NIRQ = 6,
  parameter int CW   = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int IW   = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel_wr,
  input  logic [IW-1:0]   sel_idx,
  input  logic [CW-1:0]   sel_ch,
  input  logic [NIRQ-1:0] clr,
  input  logic [NCH-1:0]  ev,
  output logic [NIRQ-1:0] pend
);

  localparam int EW = 1 << CW;

  logic [EW-1:0] ev_w;
  assign ev_w = EW'(ev);

  for (genvar k = 0; k < NIRQ; k++) begin : g_line
    logic [CW-1:0] sel_q;
    logic          pend_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q  <= CW'(k % NCH);
        pend_q <= 1'b0;
      end else begin
        if (sel_wr && sel_idx == IW'(k)) sel_q <= sel_ch;
        pend_q <= (pend_q & ~clr[k]) | ev_w[sel_q];
      end
    end

    assign pend[k] = pend_q;
  end

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq #(
  parameter  int NCH    = 12,
  parameter  int NIRQ   = 6,
  parameter  int ADDR_W = 16,
  parameter  int LEN_W  = 10,
  parameter  int IVL_W  = 8,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int IRQ_W  = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [2:0]        cfg_fld,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              irq_wr,
  input  logic [IRQ_W-1:0]  irq_idx,
  input  logic [CH_W-1:0]   irq_ch,
  input  logic [NIRQ-1:0]   irq_clr,
  output logic              out_vld,
  output logic [CH_W-1:0]   out_ch,
  output logic [ADDR_W-1:0] out_src,
  output logic [ADDR_W-1:0] out_dst,
  output logic [NIRQ-1:0]   irq_out
);

  logic [NCH-1:0]    req_vec, ev_vec, gnt_oh;
  logic [ADDR_W-1:0] src_arr [NCH];
  logic [ADDR_W-1:0] dst_arr [NCH];
  logic              gnt_vld;
  logic [CH_W-1:0]   gnt_idx;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_chan #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W),
      .IVL_W  (IVL_W)
    ) u_chan (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cfg_wr && cfg_ch == CH_W'(c)),
      .wr_fld  (cfg_fld),
      .wr_data (cfg_wdata),
      .grant   (gnt_oh[c]),
      .req     (req_vec[c]),
      .src_ptr (src_arr[c]),
      .dst_ptr (dst_arr[c]),
      .blk_end (ev_vec[c])
    );
  end

  dma_rr_arb #(
    .N (NCH),
    .W (CH_W)
  ) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (req_vec),
    .gnt_vld (gnt_vld),
    .gnt_idx (gnt_idx)
  );

  assign gnt_oh = gnt_vld ? (NCH'(1) << gnt_idx) : '0;

  dma_irq_route #(
    .NCH  (NCH),
    .NIRQ (NIRQ),
    .CW   (CH_W),
    .IW   (IRQ_W)
  ) u_irq (
    .clk     (clk),
    .rst     (rst),
    .sel_wr  (irq_wr),
    .sel_idx (irq_idx),
    .sel_ch  (irq_ch),
    .clr     (irq_clr),
    .ev      (ev_vec),
    .pend    (irq_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_ch  <= '0;
      out_src <= '0;
      out_dst <= '0;
    end else begin
      out_vld <= gnt_vld;
      if (gnt_vld) begin
        out_ch  <= gnt_idx;
        out_src <= src_arr[gnt_idx];
        out_dst <= dst_arr[gnt_idx];
      end
    end
  end

endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk #(
  parameter int NCH  = 12,
  parameter int NIRQ = 6,
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [NCH-1:0]  req_vec,
  input logic            gnt_vld,
  input logic [CH_W-1:0] gnt_idx,
  input logic            out_vld,
  input logic [CH_W-1:0] out_ch,
  input logic [NIRQ-1:0] irq_out,
  input logic [NIRQ-1:0] irq_clr
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_vld && irq_out == '0));

  // R7
  grant_from_req_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_vld |-> req_vec[gnt_idx]);

  // R7
  no_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (req_vec != '0) |-> gnt_vld);

  // R7
  out_follows_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_vld |=> (out_vld && out_ch == $past(gnt_idx)));

  // R7
  out_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (int'(out_ch) < NCH));

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ((irq_out & ~irq_clr) != '0) |=>
      ((($past(irq_out) & ~$past(irq_clr)) & ~irq_out) == '0));

endmodule

bind dma_addr_seq dma_addr_seq_chk #(
  .NCH  (NCH),
  .NIRQ (NIRQ),
  .CH_W (CH_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .req_vec (req_vec),
  .gnt_vld (gnt_vld),
  .gnt_idx (gnt_idx),
  .out_vld (out_vld),
  .out_ch  (out_ch),
  .irq_out (irq_out),
  .irq_clr (irq_clr)
);

// File: tb/dma_addr_seq_test.sv
module dma_addr_seq_test;

  localparam int NCH = 12, NIRQ = 6, ADDR_W = 16, LEN_W = 10, IVL_W = 8;
  localparam int CH_W = 4, IRQ_W = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_wr = 1'b0;
  logic [CH_W-1:0]   cfg_ch = '0;
  logic [2:0]        cfg_fld = '0;
  logic [ADDR_W-1:0] cfg_wdata = '0;
  logic              irq_wr = 1'b0;
  logic [IRQ_W-1:0]  irq_idx = '0;
  logic [CH_W-1:0]   irq_ch = '0;
  logic [NIRQ-1:0]   irq_clr = '0;
  logic              out_vld;
  logic [CH_W-1:0]   out_ch;
  logic [ADDR_W-1:0] out_src, out_dst;
  logic [NIRQ-1:0]   irq_out;

  always #10 clk = ~clk;

  dma_addr_seq #(
    .NCH(NCH), .NIRQ(NIRQ), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .IVL_W(IVL_W)
  ) uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_ch(cfg_ch), .cfg_fld(cfg_fld),
    .cfg_wdata(cfg_wdata), .irq_wr(irq_wr), .irq_idx(irq_idx), .irq_ch(irq_ch),
    .irq_clr(irq_clr), .out_vld(out_vld), .out_ch(out_ch), .out_src(out_src),
    .out_dst(out_dst), .irq_out(irq_out)
  );

  typedef logic [2*ADDR_W-1:0] pair_t;
  pair_t expq [NCH][$];

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int seen [NCH];
  int last_t [NCH];
  int en_t [NCH];
  int gap_exp [NCH];
  bit gap_on [NCH];
  bit rec_on = 1'b0;
  int rec_n = 0;
  int rec_seq [12];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Monitor: pops the scoreboard of the serviced channel
  always @(negedge clk) begin : mon
    int c;
    pair_t e;
    if (!rst) begin
      if (rec_on && rec_n < 12) begin
        rec_seq[rec_n] = out_vld ? int'(out_ch) : 99;
        rec_n++;
      end
      if (out_vld) begin
        c = int'(out_ch);
        if (c >= NCH) begin
          chk("R7 channel index in range", c, 0);
        end else begin
          if (expq[c].size() == 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R4 R11 unexpected transfer: actual ch %0d src %0h expected none",
                     c, out_src);
          end else begin
            e = expq[c].pop_front();
            chk("R3 R5 address pair", {out_src, out_dst}, e);
          end
          if (gap_on[c]) begin
            if (seen[c] == 0) chk("R2 first service delay", cyc - en_t[c], gap_exp[c]);
            else              chk("R6 service spacing", cyc - last_t[c], gap_exp[c]);
          end
          seen[c]++;
          last_t[c] = cyc;
        end
      end
    end
  end

  task automatic wr(input int ch, input int fld, input int data);
    cfg_wr = 1'b1;
    cfg_ch = CH_W'(ch);
    cfg_fld = 3'(fld);
    cfg_wdata = ADDR_W'(data);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic route(input int line, input int ch);
    irq_wr = 1'b1;
    irq_idx = IRQ_W'(line);
    irq_ch = CH_W'(ch);
    @(negedge clk);
    irq_wr = 1'b0;
  endtask

  // Driver: programs a channel and pushes its expected address pairs
  task automatic setup(input int ch, input int ss, input int ds, input int si,
                       input int di, input int len, input int ivl, input bit wrap,
                       input int nexp, input bit timed);
    wr(ch, 0, ss); wr(ch, 1, ds); wr(ch, 2, si); wr(ch, 3, di);
    wr(ch, 4, len); wr(ch, 5, ivl);
    for (int i = 0; i < nexp; i++) begin
      int k;
      k = i % len;
      expq[ch].push_back({ADDR_W'(ss + k * si), ADDR_W'(ds + k * di)});
    end
    gap_on[ch] = timed;
    gap_exp[ch] = ivl + 1;
    seen[ch] = 0;
    wr(ch, 6, wrap ? 3 : 1);
    en_t[ch] = cyc;
  endtask

  task automatic halt(input int ch);
    wr(ch, 6, 0);
    @(negedge clk);
    @(negedge clk);
    expq[ch].delete();
    gap_on[ch] = 1'b0;
  endtask

  task automatic wait_seen(input int ch, input int n);
    while (seen[ch] < n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung run expected completion");
    summary();
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < NCH; i++) begin
      seen[i] = 0; last_t[i] = 0; en_t[i] = 0; gap_exp[i] = 0; gap_on[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 out_vld after reset", out_vld, 0);
    chk("R1 irq_out after reset", irq_out, 0);
    chk("R1 out_src after reset", out_src, 0);

    // Linear channel, period 2, irq line 0 routed to it
    route(0, 7);
    setup(7, 'h100, 'h800, 4, 1, 5, 2, 1'b0, 5, 1'b1);
    wait_seen(7, 4);
    chk("R8 irq0 clear before block end", irq_out[0], 0);
    do @(negedge clk); while (!(out_vld && out_ch == 4'd7));
    chk("R8 irq0 rises with last transfer", irq_out[0], 1);
    repeat (20) @(negedge clk);
    chk("R4 linear block transfer count", seen[7], 5);
    chk("R9 irq0 sticky", irq_out[0], 1);
    chk("R10 irq1 watches idle channel 1", irq_out[1], 0);
    irq_clr = 6'b000001;
    @(negedge clk);
    irq_clr = '0;
    chk("R9 write one clears irq0", irq_out[0], 0);

    // Second period, spacing checked by the monitor
    setup(11, 'h40, 'h4000, 1, -1, 3, 6, 1'b0, 3, 1'b1);
    wait_seen(11, 3);
    repeat (10) @(negedge clk);
    chk("R6 linear ch11 count", seen[11], 3);

    // Block end in the same cycle as a clear
    route(3, 8);
    setup(8, 'h10, 'h20, 1, 1, 1, 5, 1'b0, 1, 1'b0);
    irq_clr = 6'b001000;
    repeat (6) @(negedge clk);
    chk("R9 set wins over clear", irq_out[3], 1);
    @(negedge clk);
    chk("R9 clear after set cycle", irq_out[3], 0);
    irq_clr = '0;

    // Circular channel with a negative step crossing zero
    route(1, 10);
    setup(10, 4, 'h300, -2, 'h10, 4, 0, 1'b1, 40, 1'b0);
    wait_seen(10, 10);
    halt(10);
    n = seen[10];
    repeat (20) @(negedge clk);
    chk("R11 stopped channel silent", seen[10], n);
    chk("R5 R10 rerouted irq1 set by wrap", irq_out[1], 1);

    // Three continuously requesting circular channels
    setup(2, 'h1000, 'h2000, 1, 1, 8, 0, 1'b1, 80, 1'b0);
    setup(5, 'h3000, 'h5000, 2, 3, 8, 0, 1'b1, 80, 1'b0);
    setup(9, 'h7000, 'h9000, -1, 4, 8, 0, 1'b1, 80, 1'b0);
    repeat (3) @(negedge clk);
    rec_n = 0;
    rec_on = 1'b1;
    while (rec_n < 12) @(negedge clk);
    rec_on = 1'b0;
    for (int i = 0; i < 12; i++) begin
      chk("R7 no idle cycle", rec_seq[i] == 99, 0);
      if (i >= 3) chk("R7 cyclic order", rec_seq[i], rec_seq[i-3]);
    end
    chk("R7 three distinct channels",
        (rec_seq[0] != rec_seq[1]) && (rec_seq[1] != rec_seq[2]) && (rec_seq[0] != rec_seq[2]), 1);
    wait_seen(5, 9);
    halt(2);
    halt(5);
    halt(9);
    repeat (4) @(negedge clk);
    chk("R10 default route irq5 watches ch5", irq_out[5], 1);
    chk("R10 default route irq2 watches ch2", irq_out[2], 1);

    chk("R4 ch7 queue drained", expq[7].size(), 0);
    chk("R4 ch11 queue drained", expq[11].size(), 0);
    chk("R4 ch8 queue drained", expq[8].size(), 0);

    summary();
    $finish;
  end

endmodule